// File: doc/BRIEF.md
# Immediate Priority Ceiling Manager

This unit enforces the immediate priority ceiling protocol for a fixed set of tasks sharing a fixed set of locks. Software loads a static priority for every task and a ceiling priority for every lock. The ceiling is the highest priority of any task that enters the matching critical section. The unit keeps a dynamic priority register for every task. When a task takes a free lock, that task's dynamic priority rises to the lock's ceiling in the same clock edge.

Requests arrive one per cycle as acquire or release commands. Each command carries a task number and a lock number. A task that asks for a lock already owned by another task is recorded as waiting on that lock. When the owner releases the lock, a priority encoder over that lock's waiters picks the most urgent one. Ownership moves straight to that task, and a one-cycle grant pulse names it, so the interrupt can be routed to the processor that runs it. The releasing task falls back to its static priority, or to the most urgent ceiling among the locks it still holds.

Priority values are numeric, and a smaller value is more urgent: 0 is the highest priority. The default size is 64 tasks, 8 locks and 6-bit priorities.

Top module: `ceil_mgr`

## Requirements
- R1: After reset every lock is free, every task's static and dynamic priority and every query result read the least urgent value (all ones, 63 by default), and acq_done, acq_wait and grant_valid are low.
- R2: A task priority write (cfg_task_we) sets the static priority. The dynamic priority follows it only when that task owns no lock. The write is ignored in any cycle where req_valid is high.
- R3: A lock ceiling write (cfg_lock_we) sets that lock's ceiling, which later acquires and handoffs use. Every ceiling resets to 0.
- R4: An acquire (req_op = 0) of a free lock makes the requester the owner at the next edge and pulses acq_done for one cycle. The requester's dynamic priority becomes the more urgent of its current value and the lock ceiling.
- R5: An acquire of a lock owned by a different task marks the requester as waiting on that lock and pulses acq_wait. The owner and every priority stay unchanged.
- R6: A release (req_op = 1) by the owner, with no waiters on that lock, frees the lock and gives no grant.
- R7: On a release by the owner, the owner's dynamic priority becomes the most urgent of its static priority and the ceilings of the other locks it still owns.
- R8: On a release with waiters, the waiter with the most urgent dynamic priority becomes the owner. It leaves the waiting set, and its dynamic priority becomes the more urgent of its current value and the ceiling. In the cycle after the release edge, grant_valid is high with grant_task and grant_lock naming the waiter and the lock.
- R9: Among waiters with equal dynamic priority, the lowest task number is granted.
- R10: A release by a task that is not the owner, a release of a free lock, and an acquire by the task that already owns the lock change no state and raise no pulse.
- R11: grant_valid, acq_done and acq_wait are single-cycle pulses. At most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_task_we | input | 1 | Static task priority write strobe |
| cfg_task_id | input | TW | Task written |
| cfg_task_prio | input | PW | Static priority value |
| cfg_lock_we | input | 1 | Lock ceiling write strobe |
| cfg_lock_id | input | LW | Lock written |
| cfg_lock_ceil | input | PW | Ceiling value |
| req_valid | input | 1 | Command strobe |
| req_op | input | 1 | 0 acquire, 1 release |
| req_task | input | TW | Task issuing the command |
| req_lock | input | LW | Lock addressed |
| acq_done | output | 1 | Acquire of a free lock took effect |
| acq_wait | output | 1 | Acquire was queued behind an owner |
| grant_valid | output | 1 | Lock handed to a waiter (interrupt request) |
| grant_task | output | TW | Task that received the lock |
| grant_lock | output | LW | Lock handed over |
| qry_task | input | TW | Task whose dynamic priority is read |
| qry_prio | output | PW | Dynamic priority of qry_task |
| qry_lock | input | LW | Lock whose state is read |
| qry_held | output | 1 | qry_lock is owned |
| qry_owner | output | TW | Owner of qry_lock |

## Verification
The hardest situation to reach from the ports is a release where the outgoing owner still holds other locks and several waiters share one priority. In that one edge the unit must pick the winner by priority and then by task number, restore the owner to a ceiling rather than to its static value, and raise the new owner's priority. The directed stimulus gets there with a short chain of commands. One task takes three locks with different ceilings. Two equal-priority tasks and then a more urgent, higher-numbered task queue on the locks. The locks are then released in an order that exercises each of these outcomes in turn.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  typedef enum logic {
    OP_ACQ = 1'b0,
    OP_REL = 1'b1
  } pcm_op_e;
endpackage

// File: rtl/ceil_wait_pick.sv
// Priority encoder: most urgent candidate (smallest value), lowest index on ties.
module ceil_wait_pick #(
  parameter int NTASK = 64,
  parameter int PW    = 6,
  localparam int TW   = (NTASK > 1) ? $clog2(NTASK) : 1
) (
  input  logic [NTASK-1:0]         cand,
  input  logic [NTASK-1:0][PW-1:0] prio,
  output logic                     found,
  output logic [TW-1:0]            idx
);
  logic [PW-1:0] best;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '1;
    for (int i = 0; i < NTASK; i++) begin
      // strict compare keeps the earlier (lower) index on equal priority
      if (cand[i] && (!found || prio[i] < best)) begin
        found = 1'b1;
        best  = prio[i];
        idx   = TW'(i);
      end
    end
  end
endmodule

// File: rtl/ceil_hold_min.sv
// Most urgent of a base priority and the ceilings of locks a task still owns.
module ceil_hold_min #(
  parameter int NTASK = 64,
  parameter int NLOCK = 8,
  parameter int PW    = 6,
  localparam int TW   = (NTASK > 1) ? $clog2(NTASK) : 1,
  localparam int LW   = (NLOCK > 1) ? $clog2(NLOCK) : 1
) (
  input  logic [NLOCK-1:0]         held,
  input  logic [NLOCK-1:0][TW-1:0] owner,
  input  logic [NLOCK-1:0][PW-1:0] ceil,
  input  logic [TW-1:0]            tid,
  input  logic [LW-1:0]            skip,
  input  logic [PW-1:0]            base,
  output logic [PW-1:0]            result
);
  always_comb begin
    result = base;
    for (int l = 0; l < NLOCK; l++) begin
      if (held[l] && owner[l] == tid && LW'(l) != skip && ceil[l] < result)
        result = ceil[l];
    end
  end
endmodule

// File: rtl/ceil_mgr.sv
module ceil_mgr
  import pcm_pkg::*;
#(
  parameter int NTASK = 64,
  parameter int NLOCK = 8,
  parameter int PW    = 6,
  localparam int TW   = (NTASK > 1) ? $clog2(NTASK) : 1,
  localparam int LW   = (NLOCK > 1) ? $clog2(NLOCK) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_task_we,
  input  logic [TW-1:0] cfg_task_id,
  input  logic [PW-1:0] cfg_task_prio,
  input  logic          cfg_lock_we,
  input  logic [LW-1:0] cfg_lock_id,
  input  logic [PW-1:0] cfg_lock_ceil,
  input  logic          req_valid,
  input  logic          req_op,
  input  logic [TW-1:0] req_task,
  input  logic [LW-1:0] req_lock,
  output logic          acq_done,
  output logic          acq_wait,
  output logic          grant_valid,
  output logic [TW-1:0] grant_task,
  output logic [LW-1:0] grant_lock,
  input  logic [TW-1:0] qry_task,
  output logic [PW-1:0] qry_prio,
  input  logic [LW-1:0] qry_lock,
  output logic          qry_held,
  output logic [TW-1:0] qry_owner
);
  // state
  logic [NTASK-1:0][PW-1:0]    stat_q, stat_d;
  logic [NTASK-1:0][PW-1:0]    dyn_q, dyn_d;
  logic [NLOCK-1:0][PW-1:0]    ceil_q, ceil_d;
  logic [NLOCK-1:0]            held_q, held_d;
  logic [NLOCK-1:0][TW-1:0]    owner_q, owner_d;
  logic [NLOCK-1:0][NTASK-1:0] wait_q, wait_d;
  logic                        acq_done_d, acq_wait_d, grant_d;
  logic [TW-1:0]               gtask_d;
  logic [LW-1:0]               glock_d;

  // decode
  pcm_op_e       op;
  logic          is_acq, is_rel, lk_held, is_owner, cfg_holds;
  logic          w_found;
  logic [TW-1:0] w_idx;
  logic [PW-1:0] rel_prio, lk_ceil;

  assign op       = pcm_op_e'(req_op);
  assign is_acq   = req_valid && op == OP_ACQ;
  assign is_rel   = req_valid && op == OP_REL;
  assign lk_held  = held_q[req_lock];
  assign lk_ceil  = ceil_q[req_lock];
  assign is_owner = lk_held && owner_q[req_lock] == req_task;

  always_comb begin
    cfg_holds = 1'b0;
    for (int l = 0; l < NLOCK; l++)
      if (held_q[l] && owner_q[l] == cfg_task_id) cfg_holds = 1'b1;
  end

  ceil_wait_pick #(.NTASK(NTASK), .PW(PW)) i_pick (
    .cand  (wait_q[req_lock]),
    .prio  (dyn_q),
    .found (w_found),
    .idx   (w_idx)
  );

  ceil_hold_min #(.NTASK(NTASK), .NLOCK(NLOCK), .PW(PW)) i_restore (
    .held   (held_q),
    .owner  (owner_q),
    .ceil   (ceil_q),
    .tid    (req_task),
    .skip   (req_lock),
    .base   (stat_q[req_task]),
    .result (rel_prio)
  );

  // next state
  always_comb begin
    stat_d     = stat_q;
    dyn_d      = dyn_q;
    ceil_d     = ceil_q;
    held_d     = held_q;
    owner_d    = owner_q;
    wait_d     = wait_q;
    acq_done_d = 1'b0;
    acq_wait_d = 1'b0;
    grant_d    = 1'b0;
    gtask_d    = grant_task;
    glock_d    = grant_lock;

    if (cfg_lock_we) ceil_d[cfg_lock_id] = cfg_lock_ceil;

    if (cfg_task_we && !req_valid) begin
      stat_d[cfg_task_id] = cfg_task_prio;
      if (!cfg_holds) dyn_d[cfg_task_id] = cfg_task_prio;
    end

    if (is_acq) begin
      if (!lk_held) begin
        held_d[req_lock]  = 1'b1;
        owner_d[req_lock] = req_task;
        if (lk_ceil < dyn_q[req_task]) dyn_d[req_task] = lk_ceil;
        acq_done_d = 1'b1;
      end else if (!is_owner) begin
        wait_d[req_lock][req_task] = 1'b1;
        acq_wait_d = 1'b1;
      end
    end

    if (is_rel && is_owner) begin
      dyn_d[req_task] = rel_prio;
      if (w_found) begin
        owner_d[req_lock]       = w_idx;
        wait_d[req_lock][w_idx] = 1'b0;
        if (lk_ceil < dyn_q[w_idx]) dyn_d[w_idx] = lk_ceil;
        grant_d = 1'b1;
        gtask_d = w_idx;
        glock_d = req_lock;
      end else begin
        held_d[req_lock] = 1'b0;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q      <= '1;
      dyn_q       <= '1;
      ceil_q      <= '0;
      held_q      <= '0;
      owner_q     <= '0;
      wait_q      <= '0;
      acq_done    <= 1'b0;
      acq_wait    <= 1'b0;
      grant_valid <= 1'b0;
      grant_task  <= '0;
      grant_lock  <= '0;
    end else begin
      stat_q      <= stat_d;
      dyn_q       <= dyn_d;
      ceil_q      <= ceil_d;
      held_q      <= held_d;
      owner_q     <= owner_d;
      wait_q      <= wait_d;
      acq_done    <= acq_done_d;
      acq_wait    <= acq_wait_d;
      grant_valid <= grant_d;
      grant_task  <= gtask_d;
      grant_lock  <= glock_d;
    end
  end

  assign qry_prio  = dyn_q[qry_task];
  assign qry_held  = held_q[qry_lock];
  assign qry_owner = owner_q[qry_lock];
endmodule

// File: rtl/ceil_mgr_chk.sv
module ceil_mgr_chk #(
  parameter int NTASK = 64,
  parameter int NLOCK = 8,
  parameter int PW    = 6,
  localparam int TW   = (NTASK > 1) ? $clog2(NTASK) : 1,
  localparam int LW   = (NLOCK > 1) ? $clog2(NLOCK) : 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     req_op,
  input logic                     acq_done,
  input logic                     acq_wait,
  input logic                     grant_valid,
  input logic [TW-1:0]            grant_task,
  input logic [LW-1:0]            grant_lock,
  input logic [NLOCK-1:0]         held_q,
  input logic [NLOCK-1:0][TW-1:0] owner_q,
  input logic [NLOCK-1:0][NTASK-1:0] wait_q
);
  // R4: acq_done only follows an acquire command
  a_r4_done_after_acquire: assert property (@(posedge clk) disable iff (!rst_n)
    acq_done |-> ($past(req_valid) && !$past(req_op)));

  // R5: acq_wait only follows an acquire command
  a_r5_wait_after_acquire: assert property (@(posedge clk) disable iff (!rst_n)
    acq_wait |-> ($past(req_valid) && !$past(req_op)));

  // R8: a grant only follows a release command
  a_r8_grant_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> ($past(req_valid) && $past(req_op)));

  // R8: the granted task is the owner of the granted lock
  a_r8_grant_owns_lock: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (held_q[grant_lock] && owner_q[grant_lock] == grant_task));

  // R11: one outcome per command
  a_r11_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({acq_done, acq_wait, grant_valid}) <= 1);

  for (genvar l = 0; l < NLOCK; l++) begin : g_lock
    // R5: waiters exist only behind an owner
    a_r5_waiters_need_owner: assert property (@(posedge clk) disable iff (!rst_n)
      (|wait_q[l]) |-> held_q[l]);
    // R10: an owner never waits on its own lock
    a_r10_owner_not_waiting: assert property (@(posedge clk) disable iff (!rst_n)
      held_q[l] |-> !wait_q[l][owner_q[l]]);
  end
endmodule

bind ceil_mgr ceil_mgr_chk #(.NTASK(NTASK), .NLOCK(NLOCK), .PW(PW)) i_ceil_mgr_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_op      (req_op),
  .acq_done    (acq_done),
  .acq_wait    (acq_wait),
  .grant_valid (grant_valid),
  .grant_task  (grant_task),
  .grant_lock  (grant_lock),
  .held_q      (held_q),
  .owner_q     (owner_q),
  .wait_q      (wait_q)
);

// File: tb/test_ceil_mgr.sv
module test_ceil_mgr;
  localparam int CLK_PERIOD = 10;
  localparam int NTASK = 64;
  localparam int NLOCK = 8;
  localparam int PW    = 6;
  localparam int TW    = 6;
  localparam int LW    = 3;
  localparam int WATCHDOG = 5000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_task_we, cfg_lock_we, req_valid, req_op;
  logic [TW-1:0] cfg_task_id, req_task, qry_task, grant_task, qry_owner;
  logic [LW-1:0] cfg_lock_id, req_lock, qry_lock, grant_lock;
  logic [PW-1:0] cfg_task_prio, cfg_lock_ceil, qry_prio;
  logic          acq_done, acq_wait, grant_valid, qry_held;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ceil_mgr #(.NTASK(NTASK), .NLOCK(NLOCK), .PW(PW)) i_ceil_mgr (
    .clk(clk), .rst_n(rst_n),
    .cfg_task_we(cfg_task_we), .cfg_task_id(cfg_task_id), .cfg_task_prio(cfg_task_prio),
    .cfg_lock_we(cfg_lock_we), .cfg_lock_id(cfg_lock_id), .cfg_lock_ceil(cfg_lock_ceil),
    .req_valid(req_valid), .req_op(req_op), .req_task(req_task), .req_lock(req_lock),
    .acq_done(acq_done), .acq_wait(acq_wait), .grant_valid(grant_valid),
    .grant_task(grant_task), .grant_lock(grant_lock),
    .qry_task(qry_task), .qry_prio(qry_prio), .qry_lock(qry_lock),
    .qry_held(qry_held), .qry_owner(qry_owner)
  );

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cmd(input bit op, input int t, input int l);
    req_valid = 1'b1; req_op = op; req_task = TW'(t); req_lock = LW'(l);
    tick();
    req_valid = 1'b0;
  endtask

  task automatic set_task(input int t, input int p);
    cfg_task_we = 1'b1; cfg_task_id = TW'(t); cfg_task_prio = PW'(p);
    tick();
    cfg_task_we = 1'b0;
  endtask

  task automatic set_lock(input int l, input int c);
    cfg_lock_we = 1'b1; cfg_lock_id = LW'(l); cfg_lock_ceil = PW'(c);
    tick();
    cfg_lock_we = 1'b0;
  endtask

  task automatic chk_prio(input string rq, input int t, input int exp);
    qry_task = TW'(t); #1;
    chk(rq, $sformatf("prio of task %0d", t), int'(qry_prio), exp);
  endtask

  task automatic chk_lock(input string rq, input int l, input int held, input int own);
    qry_lock = LW'(l); #1;
    chk(rq, $sformatf("held of lock %0d", l), int'(qry_held), held);
    if (held != 0) chk(rq, $sformatf("owner of lock %0d", l), int'(qry_owner), own);
  endtask

  task automatic chk_pulses(input string rq, input int d, input int w, input int g);
    chk(rq, "acq_done", int'(acq_done), d);
    chk(rq, "acq_wait", int'(acq_wait), w);
    chk(rq, "grant_valid", int'(grant_valid), g);
  endtask

  task automatic t_reset();
    chk_pulses("R1", 0, 0, 0);
    chk_prio("R1", 5, 63);
    chk_prio("R1", 63, 63);
    chk_lock("R1", 3, 0, 0);
  endtask

  task automatic t_config();
    set_task(1, 10); set_task(2, 20); set_task(3, 30); set_task(4, 20); set_task(5, 5);
    set_lock(0, 10); set_lock(1, 5); set_lock(2, 15);
    chk_prio("R2", 2, 20);
    chk_prio("R2", 5, 5);
  endtask

  task automatic t_acquire();
    cmd(0, 3, 0);
    chk_pulses("R4", 1, 0, 0);
    chk_lock("R4", 0, 1, 3);
    chk_prio("R4", 3, 10);
    tick();
    chk_pulses("R11", 0, 0, 0);
    cmd(0, 2, 0);
    chk_pulses("R5", 0, 1, 0);
    chk_lock("R5", 0, 1, 3);
    chk_prio("R5", 2, 20);
    chk_prio("R5", 3, 10);
    cmd(0, 4, 0);
    chk_pulses("R5", 0, 1, 0);
  endtask

  task automatic t_nesting();
    cmd(0, 3, 2);
    chk_prio("R4", 3, 10);
    cmd(0, 3, 1);
    chk_prio("R3", 3, 5);
    cmd(1, 3, 1);
    chk_pulses("R6", 0, 0, 0);
    chk_lock("R6", 1, 0, 0);
    chk_prio("R7", 3, 10);
  endtask

  task automatic t_ignored();
    cmd(1, 4, 0);
    chk_pulses("R10", 0, 0, 0);
    chk_lock("R10", 0, 1, 3);
    cmd(0, 3, 0);
    chk_pulses("R10", 0, 0, 0);
    chk_prio("R10", 3, 10);
    cmd(1, 6, 5);
    chk_pulses("R10", 0, 0, 0);
    chk_lock("R10", 5, 0, 0);
  endtask

  task automatic t_handoff_tie();
    cmd(1, 3, 0);
    chk("R9", "grant_valid", int'(grant_valid), 1);
    chk("R9", "grant_task", int'(grant_task), 2);
    chk("R8", "grant_lock", int'(grant_lock), 0);
    chk_lock("R8", 0, 1, 2);
    chk_prio("R8", 2, 10);
    chk_prio("R7", 3, 15);
    tick();
    chk("R11", "grant_valid", int'(grant_valid), 0);
    cmd(1, 2, 0);
    chk("R8", "grant_task", int'(grant_task), 4);
    chk_prio("R7", 2, 20);
    chk_prio("R8", 4, 10);
  endtask

  task automatic t_handoff_prio();
    cmd(0, 5, 2);
    chk_pulses("R5", 0, 1, 0);
    cmd(0, 1, 2);
    cmd(1, 3, 2);
    chk("R8", "grant_valid", int'(grant_valid), 1);
    chk("R8", "grant_task", int'(grant_task), 5);
    chk("R8", "grant_lock", int'(grant_lock), 2);
    chk_prio("R7", 3, 30);
    chk_prio("R8", 5, 5);
  endtask

  task automatic t_release_free();
    cmd(1, 4, 0);
    chk_pulses("R6", 0, 0, 0);
    chk_lock("R6", 0, 0, 0);
    chk_prio("R6", 4, 20);
  endtask

  task automatic t_cfg_rules();
    set_task(5, 40);
    chk_prio("R2", 5, 5);
    cmd(1, 5, 2);
    chk("R8", "grant_task", int'(grant_task), 1);
    chk_prio("R2", 5, 40);
    chk_prio("R8", 1, 10);
    cfg_task_we = 1'b1; cfg_task_id = TW'(6); cfg_task_prio = PW'(1);
    cmd(0, 6, 4);
    cfg_task_we = 1'b0;
    chk_pulses("R4", 1, 0, 0);
    chk_prio("R3", 6, 0);
    cmd(1, 6, 4);
    chk_prio("R2", 6, 63);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_task_we = 1'b0; cfg_task_id = '0; cfg_task_prio = '0;
    cfg_lock_we = 1'b0; cfg_lock_id = '0; cfg_lock_ceil = '0;
    req_valid = 1'b0; req_op = 1'b0; req_task = '0; req_lock = '0;
    qry_task = '0; qry_lock = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_config();
    t_acquire();
    t_nesting();
    t_ignored();
    t_handoff_tie();
    t_handoff_prio();
    t_release_free();
    t_cfg_rules();
    report();
    $finish;
  end
endmodule